// File: doc/BRIEF.md
# Periodic Clock Drift Compensator

This block sits between a slow timekeeping pulse (nominally 32.768 kHz, delivered as a one-cycle enable `tick_i`) and the seconds chain of a real-time clock. A prescaler divides the ticks into seconds. Seconds are grouped into correction intervals of either 20 or 60 seconds. In the final second of every interval, the prescaler's terminal count is moved by an even number of ticks. This trims the long-term frequency error of the oscillator.

Moving the count down adds pulses: the second ends early and the clock runs faster. Moving it up removes pulses: the second is stretched and the clock runs slower.

Software programs one 8-bit trim setting, which holds the following fields:
- the step magnitude code in bits [5:0];
- the direction in bit 6;
- the interval length in bit 7.

A write is held as pending until the next interval boundary. A busy flag stays high from the write until that boundary, and software waits for it to drop before writing again.

The block emits a one-cycle pulse at the end of every second. It emits a second one-cycle pulse at the end of every correction interval. The seconds chain downstream consumes these pulses.

Top module: `drift_comp`

## Requirements
- R1: After reset, `busy_o` is 0, `cfg_o` is 0x00, and `sec_pulse_o` and `intv_pulse_o` are 0.
- R2: The prescaler advances only on cycles with `tick_i` high. An uncorrected second lasts exactly `TICKS_PER_SEC` ticks, and `sec_pulse_o` pulses for one cycle when it ends.
- R3: Bit 7 of the active setting selects the interval length: 0 gives `SHORT_SECS` seconds and 1 gives `LONG_SECS` seconds. `intv_pulse_o` pulses together with the `sec_pulse_o` of the last second of each interval.
- R4: With bit 6 = 0 (add), a code c in bits [5:0] with c ≥ 1 shortens the last second of each interval by 2·(c−1) ticks. Code 1 gives no change, and code 63 gives the maximum of 124.
- R5: With bit 6 = 1 (subtract), a code c in 2..63 lengthens the last second by 2·((~c & 0x3F)+1) ticks. Code 63 gives 2 ticks. Code 1 saturates to the 62-step maximum of 124 ticks.
- R6: A code of 0 in bits [5:0] applies no correction, whatever the value of bit 6.
- R7: A write (`wr_en_i`) while `busy_o` is 0 raises `busy_o` on the next cycle. The value reaches `cfg_o` and takes effect at the next interval boundary, in the same cycle as `intv_pulse_o`, and `busy_o` drops in that cycle. The interval that is running when the write arrives keeps the previous setting.
- R8: A write while `busy_o` is 1 is ignored. The value that was pending is the one committed.
- R9: Only the last second of an interval is corrected. All other seconds last `TICKS_PER_SEC` ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | Slow-oscillator pulse enable, one cycle per oscillator period |
| wr_en_i | input | 1 | Write strobe for the trim setting |
| wr_data_i | input | 8 | Trim setting: [5:0] code, [6] subtract, [7] long interval |
| cfg_o | output | 8 | Trim setting currently in effect |
| busy_o | output | 1 | A written setting is pending until the next interval boundary |
| sec_pulse_o | output | 1 | One-cycle pulse at the end of every second |
| intv_pulse_o | output | 1 | One-cycle pulse at the end of every correction interval |

## Verification
A wrong decode of the code or direction stays invisible for a whole interval. It shows only as a wrong length for the closing second, which the bench times in ticks. A seconds counter that drifts out of step with the interval shows up instead as a misplaced `intv_pulse_o`, or as a trimmed second in the wrong position, within one interval. A pending register or busy flag that commits at the wrong time shows in `cfg_o` and `busy_o` at the first boundary after the write. Writes during busy are compared against the value finally committed.

// File: rtl/drift_pkg.sv
package drift_pkg;

  localparam int CODE_W     = 6;
  localparam int PULSE_W    = 7;
  localparam int MAX_PULSES = 124;

  typedef struct packed {
    logic              long_intv;
    logic              subtract;
    logic [CODE_W-1:0] code;
  } trim_cfg_t;

  // Number of ticks to move the terminal count, always even.
  function automatic logic [PULSE_W-1:0] trim_pulses(input trim_cfg_t cfg);
    logic [CODE_W-1:0] inv;
    logic [PULSE_W-1:0] steps;
    inv   = ~cfg.code;
    steps = '0;
    if (cfg.code == '0) begin
      steps = '0;
    end else if (!cfg.subtract) begin
      steps = PULSE_W'(cfg.code) - PULSE_W'(1);
    end else if (cfg.code == CODE_W'(1)) begin
      steps = PULSE_W'(MAX_PULSES / 2);
    end else begin
      steps = PULSE_W'(inv) + PULSE_W'(1);
    end
    return PULSE_W'(steps << 1);
  endfunction

endpackage

// File: rtl/drift_cfg_regs.sv
module drift_cfg_regs
  import drift_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  trim_cfg_t wr_data,
  input  logic      boundary,
  output trim_cfg_t active,
  output logic      busy
);

  trim_cfg_t pending_q, pending_d;
  trim_cfg_t active_q, active_d;
  logic      busy_q, busy_d;
  logic      accept;

  assign accept = wr_en && !busy_q;

  always_comb begin
    pending_d = pending_q;
    active_d  = active_q;
    busy_d    = busy_q;
    if (boundary && busy_q) begin
      active_d = pending_q;
      busy_d   = 1'b0;
    end
    if (accept) begin
      pending_d = wr_data;
      busy_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= '0;
      active_q  <= '0;
      busy_q    <= 1'b0;
    end else begin
      pending_q <= pending_d;
      active_q  <= active_d;
      busy_q    <= busy_d;
    end
  end

  assign active = active_q;
  assign busy   = busy_q;

endmodule

// File: rtl/drift_trim_decode.sv
module drift_trim_decode
  import drift_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int PW            = 16
) (
  input  trim_cfg_t       active,
  input  logic            trim_sec,
  output logic [PW-1:0]   limit
);

  logic [PULSE_W-1:0] pulses;
  logic [PW-1:0]      nominal;
  logic [PW-1:0]      trimmed;

  assign nominal = PW'(TICKS_PER_SEC);
  assign pulses  = trim_pulses(active);

  always_comb begin
    if (active.subtract) trimmed = nominal + PW'(pulses);
    else                 trimmed = nominal - PW'(pulses);
    limit = trim_sec ? trimmed : nominal;
  end

endmodule

// File: rtl/drift_prescaler.sv
module drift_prescaler #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [PW-1:0] limit,
  output logic          wrap,
  output logic [PW-1:0] cnt
);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = tick;
  assign wrap   = tick && (cnt_q == limit - PW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = wrap ? '0 : cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/drift_interval_ctr.sv
module drift_interval_ctr #(
  parameter int SHORT_SECS = 20,
  parameter int LONG_SECS  = 60,
  parameter int SW         = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_wrap,
  input  logic long_intv,
  output logic last_sec,
  output logic boundary
);

  logic [SW-1:0] sec_q, sec_d;
  logic [SW-1:0] final_idx;

  assign final_idx = long_intv ? SW'(LONG_SECS - 1) : SW'(SHORT_SECS - 1);
  assign last_sec  = (sec_q == final_idx);
  assign boundary  = sec_wrap && last_sec;

  always_comb begin
    sec_d = sec_q;
    if (sec_wrap) sec_d = last_sec ? '0 : sec_q + SW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sec_q <= '0;
    else        sec_q <= sec_d;
  end

endmodule

// File: rtl/drift_comp.sv
module drift_comp
  import drift_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int SHORT_SECS    = 20,
  parameter int LONG_SECS     = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] cfg_o,
  output logic       busy_o,
  output logic       sec_pulse_o,
  output logic       intv_pulse_o
);

  localparam int PW = $clog2(TICKS_PER_SEC + MAX_PULSES + 1);
  localparam int SW = $clog2(LONG_SECS + 1);

  trim_cfg_t     active;
  logic          busy;
  logic [PW-1:0] limit;
  logic [PW-1:0] presc_cnt;
  logic          sec_wrap;
  logic          last_sec;
  logic          boundary;
  logic          sec_pulse_q, intv_pulse_q;

  drift_cfg_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en_i),
    .wr_data  (trim_cfg_t'(wr_data_i)),
    .boundary (boundary),
    .active   (active),
    .busy     (busy)
  );

  drift_trim_decode #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .PW            (PW)
  ) u_decode (
    .active   (active),
    .trim_sec (last_sec),
    .limit    (limit)
  );

  drift_prescaler #(
    .PW (PW)
  ) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick_i),
    .limit (limit),
    .wrap  (sec_wrap),
    .cnt   (presc_cnt)
  );

  drift_interval_ctr #(
    .SHORT_SECS (SHORT_SECS),
    .LONG_SECS  (LONG_SECS),
    .SW         (SW)
  ) u_intv (
    .clk       (clk),
    .rst_n     (rst_n),
    .sec_wrap  (sec_wrap),
    .long_intv (active.long_intv),
    .last_sec  (last_sec),
    .boundary  (boundary)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_pulse_q  <= 1'b0;
      intv_pulse_q <= 1'b0;
    end else begin
      sec_pulse_q  <= sec_wrap;
      intv_pulse_q <= boundary;
    end
  end

  assign cfg_o        = active;
  assign busy_o       = busy;
  assign sec_pulse_o  = sec_pulse_q;
  assign intv_pulse_o = intv_pulse_q;

endmodule

// File: rtl/drift_comp_chk.sv
module drift_comp_chk #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int PW            = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_i,
  input logic          wr_en_i,
  input logic [7:0]    cfg_o,
  input logic          busy_o,
  input logic          sec_pulse_o,
  input logic          intv_pulse_o,
  input logic [PW-1:0] presc_cnt,
  input logic [PW-1:0] limit
);

  assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(presc_cnt));

  assert_cnt_below_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    presc_cnt < limit);

  assert_limit_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (limit <= PW'(TICKS_PER_SEC + 124)) && (limit >= PW'(TICKS_PER_SEC - 124)));

  assert_intv_with_sec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    intv_pulse_o |-> sec_pulse_o);

  assert_busy_set_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !busy_o) |=> busy_o);

  assert_busy_clears_at_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> intv_pulse_o);

  assert_cfg_moves_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> intv_pulse_o);

endmodule

bind drift_comp drift_comp_chk #(
  .TICKS_PER_SEC (TICKS_PER_SEC),
  .PW            (PW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_i       (tick_i),
  .wr_en_i      (wr_en_i),
  .cfg_o        (cfg_o),
  .busy_o       (busy_o),
  .sec_pulse_o  (sec_pulse_o),
  .intv_pulse_o (intv_pulse_o),
  .presc_cnt    (presc_cnt),
  .limit        (limit)
);

// File: tb/drift_comp_bench.sv
module drift_comp_bench;

  localparam int DIV   = 200;
  localparam int SHORT = 2;
  localparam int LONG  = 3;

  logic       clk;
  logic       rst_n;
  logic       tick_i;
  logic       wr_en_i;
  logic [7:0] wr_data_i;
  logic [7:0] cfg_o;
  logic       busy_o;
  logic       sec_pulse_o;
  logic       intv_pulse_o;

  int checks   = 0;
  int failures = 0;
  int cyc      = 0;
  int last_cyc = 0;
  int cur_last = DIV;
  bit half     = 1'b0;

  drift_comp #(
    .TICKS_PER_SEC (DIV),
    .SHORT_SECS    (SHORT),
    .LONG_SECS     (LONG)
  ) u_drift_comp (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .cfg_o        (cfg_o),
    .busy_o       (busy_o),
    .sec_pulse_o  (sec_pulse_o),
    .intv_pulse_o (intv_pulse_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Waits for the next second pulse; returns its length in cycles and the interval flag.
  task automatic next_sec(output int len, output bit iv);
    int guard;
    guard = 0;
    do begin
      @(negedge clk);
      if (half) tick_i = ~tick_i;
      guard++;
      if (guard > 4000) begin
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", guard, 0);
        finish_run();
      end
    end while (!sec_pulse_o);
    len      = cyc - last_cyc;
    last_cyc = cyc;
    iv       = intv_pulse_o;
  endtask

  task automatic write_cfg(input logic [7:0] v);
    wr_en_i   = 1'b1;
    wr_data_i = v;
    @(negedge clk);
    wr_en_i   = 1'b0;
  endtask

  task automatic sync_intv();
    int l;
    bit iv;
    do next_sec(l, iv); while (!iv);
  endtask

  function automatic int nsec_of(input logic [7:0] v);
    return v[7] ? LONG : SHORT;
  endfunction

  // Called right after an interval pulse. Commits v, checks the old interval,
  // then checks one interval under the new setting.
  task automatic apply(input logic [7:0] v, input int exp_last, input string req);
    int l;
    bit iv;
    int old_n;
    old_n = nsec_of(cfg_o);
    write_cfg(v);
    chk("R7 busy after write", busy_o, 1);
    for (int i = 0; i < old_n; i++) begin
      next_sec(l, iv);
      chk("R7 old setting kept", l, (i == old_n - 1) ? cur_last : DIV);
    end
    chk("R7 boundary flag", iv, 1);
    chk("R7 busy cleared at boundary", busy_o, 0);
    chk("R7 committed cfg", cfg_o, v);
    cur_last = exp_last;
    for (int i = 0; i < nsec_of(v); i++) begin
      next_sec(l, iv);
      if (i == nsec_of(v) - 1) begin
        chk(req, l, exp_last);
        chk("R3 interval end flag", iv, 1);
      end else begin
        chk("R9 untrimmed second", l, DIV);
        chk("R3 no interval flag mid-interval", iv, 0);
      end
    end
  endtask

  task automatic t_reset();
    chk("R1 busy", busy_o, 0);
    chk("R1 cfg", cfg_o, 0);
    chk("R1 sec pulse", sec_pulse_o, 0);
    chk("R1 intv pulse", intv_pulse_o, 0);
  endtask

  task automatic t_nominal();
    int l;
    bit iv;
    for (int i = 0; i < 4; i++) begin
      next_sec(l, iv);
      chk("R2 nominal second", l, DIV);
      chk("R3 short interval flag", iv, (i % 2) == 1);
    end
  endtask

  task automatic t_ignore_busy();
    int l;
    bit iv;
    write_cfg(8'h7E);
    chk("R8 busy set", busy_o, 1);
    write_cfg(8'h07);
    for (int i = 0; i < SHORT; i++) next_sec(l, iv);
    chk("R8 second write ignored", cfg_o, 8'h7E);
    chk("R7 old trim in running interval", l, cur_last);
    cur_last = DIV + 4;
    next_sec(l, iv);
    chk("R9 first second untrimmed", l, DIV);
    next_sec(l, iv);
    chk("R5 subtract code 62", l, DIV + 4);
  endtask

  task automatic t_half_rate();
    int l;
    bit iv;
    half   = 1'b1;
    tick_i = 1'b0;
    for (int i = 0; i < LONG; i++) begin
      next_sec(l, iv);
      chk("R2 half-rate ticks", l, (i == LONG - 1) ? 2 * (DIV - 8) : 2 * DIV);
    end
    chk("R3 long interval flag", iv, 1);
    half   = 1'b0;
    tick_i = 1'b1;
  endtask

  initial begin
    rst_n     = 1'b0;
    tick_i    = 1'b1;
    wr_en_i   = 1'b0;
    wr_data_i = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    sync_intv();
    t_nominal();
    apply(8'h05, DIV - 8,   "R4 add code 5");
    t_ignore_busy();
    apply(8'h41, DIV + 124, "R5 subtract code 1 saturates");
    apply(8'h7F, DIV + 2,   "R5 subtract code 63");
    apply(8'h3F, DIV - 124, "R4 add code 63");
    apply(8'h01, DIV,       "R4 add code 1");
    apply(8'h40, DIV,       "R6 subtract code 0");
    apply(8'h00, DIV,       "R6 add code 0");
    apply(8'h85, DIV - 8,   "R3 long interval add code 5");
    t_half_rate();
    finish_run();
  end

  initial begin
    #1900000;
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

endmodule